// File: doc/BRIEF.md
# Linear Page Table Walker

This block performs a hardware walk of a single-level linear page table. A translation request carries a 32-bit virtual address, an access kind (read, write or execute) and the table base address. The block splits the address into a 4 KB page number and a 12-bit offset, forms the entry address, fetches the 32-bit entry over a request/response memory port and checks it. It then reports either a physical address or one of two faults.

The frame number and permission bits of the fetched entry are returned with every result, so that a translation cache beside the walker can be refilled.

The walk moves through four states. IDLE accepts a request (transition *accept*). FETCH holds the memory request until it is taken (*granted*). WAIT holds until the response arrives (*returned*). CHECK decides the outcome and always goes back to IDLE (*finish*), with the result registered and a one-cycle done pulse.

Entry layout:

| Bits | Meaning |
|------|---------|
| 0 | valid |
| 1 | may read |
| 2 | may write |
| 3 | may execute |
| 31:12 | frame number |

Access codes: 0 read, 1 write, 2 execute, 3 reserved.

Fault codes: 0 none, 1 invalid entry, 2 protection.

Top module: `ptw_walker`

## Requirements
- R1: After reset, busy, done and mem_req_valid are 0, and fault and paddr read 0.
- R2: The entry address on mem_req_addr is base + (vaddr >> 12) * 4. mem_req_valid stays high with a stable address until a cycle in which mem_req_ready is high, and then drops.
- R3: No result appears before the entry returns. done rises in the second cycle after the cycle in which mem_rsp_valid is high.
- R4: An entry with bit 0 clear gives fault code 1 and paddr 0.
- R5: A valid entry whose permission bit for the access is clear gives fault code 2 and paddr 0. Read needs bit 1, write needs bit 2 and execute needs bit 3. Access code 3 always gives fault code 2.
- R6: A permitted access gives fault code 0 and paddr = {entry[31:12], vaddr[11:0]}.
- R7: With every result, pte_pfn shows entry[31:12] and pte_perm shows entry[3:1] of the fetched entry, faults included.
- R8: done is high for exactly one cycle per walk. busy is high from the cycle after acceptance until done, and is low while done is high.
- R9: req_valid while busy is ignored: the running walk's address and result are unchanged, and no second walk starts.
- R10: An invalid entry reports fault code 1 even when its permission bits would forbid the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | start a walk (taken only when idle) |
| req_vaddr | input | 32 | virtual address to translate |
| req_access | input | 2 | access code |
| req_base | input | 32 | page table base address |
| mem_req_valid | output | 1 | entry read request |
| mem_req_ready | input | 1 | memory takes the request |
| mem_req_addr | output | 32 | entry address |
| mem_rsp_valid | input | 1 | entry data valid |
| mem_rsp_data | input | 32 | fetched entry |
| busy | output | 1 | walk in progress |
| done | output | 1 | one-cycle result strobe |
| fault | output | 2 | fault code |
| paddr | output | 32 | physical address |
| pte_pfn | output | 20 | fetched frame number |
| pte_perm | output | 3 | fetched execute/write/read bits |

## Verification
The bench stalls the memory handshake on both sides to catch a walker that drops or changes its request before the grant, or that reports before the entry arrives. Such a design would show done early or a changed address. Each access kind is paired with an entry that lacks exactly that permission, to expose a permission bit that is swapped or ignored. The reserved code and an invalid entry with no permissions check the fault codes and their order: the wrong order would report a protection fault where an invalid entry should win. A stray request during a walk targets a different page, so a design that took it would fetch or report the wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CHECK = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROTECT = 2'd2
    } fault_e;

    localparam int ENTRY_VALID_BIT = 0;
    localparam int ENTRY_PERM_LSB  = 1;
    localparam int ENTRY_PERM_W    = 3;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRY_SIZE = 4
) (
    input  logic [ADDR_W-1:0]            vaddr,
    input  logic [ADDR_W-1:0]            base,
    output logic [ADDR_W-1:0]            entry_addr,
    output logic [PAGE_SHIFT-1:0]        offset
);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_SIZE);
    localparam int VPN_W       = ADDR_W - PAGE_SHIFT;

    logic [VPN_W-1:0]  vpn;
    logic [ADDR_W-1:0] scaled;

    always_comb begin
        vpn        = vaddr[ADDR_W-1:PAGE_SHIFT];
        offset     = vaddr[PAGE_SHIFT-1:0];
        scaled     = ADDR_W'(vpn) << ENTRY_SHIFT;
        entry_addr = base + scaled;
    end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0]            entry,
    input  logic [1:0]                   access,
    input  logic [PAGE_SHIFT-1:0]        offset,
    output logic [1:0]                   fault_code,
    output logic [ADDR_W-1:0]            phys,
    output logic [ADDR_W-PAGE_SHIFT-1:0] frame,
    output logic [ENTRY_PERM_W-1:0]      perm
);
    localparam int FRAME_W = ADDR_W - PAGE_SHIFT;

    logic allowed;

    always_comb begin
        frame = entry[ADDR_W-1 -: FRAME_W];
        perm  = entry[ENTRY_PERM_LSB +: ENTRY_PERM_W];
        unique case (access)
            ACC_READ:  allowed = perm[0];
            ACC_WRITE: allowed = perm[1];
            ACC_EXEC:  allowed = perm[2];
            default:   allowed = 1'b0;
        endcase
        if (!entry[ENTRY_VALID_BIT]) begin
            fault_code = FLT_INVALID;
            phys       = '0;
        end else if (!allowed) begin
            fault_code = FLT_PROTECT;
            phys       = '0;
        end else begin
            fault_code = FLT_NONE;
            phys       = {frame, offset};
        end
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    output walk_state_e state,
    output logic        accept,
    output logic        capture,
    output logic        finish,
    output logic        mem_req_valid,
    output logic        busy
);
    walk_state_e next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (req_valid)     next_state = ST_FETCH;
            ST_FETCH: if (mem_req_ready) next_state = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) next_state = ST_CHECK;
            ST_CHECK:                    next_state = ST_IDLE;
            default:                     next_state = ST_IDLE;
        endcase
    end

    always_comb begin
        accept        = (state == ST_IDLE) && req_valid;
        capture       = (state == ST_WAIT) && mem_rsp_valid;
        finish        = (state == ST_CHECK);
        mem_req_valid = (state == ST_FETCH);
        busy          = (state != ST_IDLE);
    end

    AST_CHECK_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |-> $past(mem_rsp_valid)); // R3
    AST_FETCH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(req_valid)); // R9
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRY_SIZE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_vaddr,
    input  logic [1:0]                   req_access,
    input  logic [ADDR_W-1:0]            req_base,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [ADDR_W-1:0]            mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [ADDR_W-1:0]            mem_rsp_data,
    output logic                         busy,
    output logic                         done,
    output logic [1:0]                   fault,
    output logic [ADDR_W-1:0]            paddr,
    output logic [ADDR_W-PAGE_SHIFT-1:0] pte_pfn,
    output logic [ENTRY_PERM_W-1:0]      pte_perm
);
    localparam int FRAME_W = ADDR_W - PAGE_SHIFT;

    walk_state_e            state;
    logic                   accept, capture, finish;
    logic [ADDR_W-1:0]      vaddr_q, base_q, entry_q;
    logic [1:0]             access_q;
    logic [PAGE_SHIFT-1:0]  offset;
    logic [1:0]             chk_fault;
    logic [ADDR_W-1:0]      chk_phys;
    logic [FRAME_W-1:0]     chk_frame;
    logic [ENTRY_PERM_W-1:0] chk_perm;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .state         (state),
        .accept        (accept),
        .capture       (capture),
        .finish        (finish),
        .mem_req_valid (mem_req_valid),
        .busy          (busy)
    );

    ptw_addr_gen #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .ENTRY_SIZE (ENTRY_SIZE)
    ) u_addr (
        .vaddr      (vaddr_q),
        .base       (base_q),
        .entry_addr (mem_req_addr),
        .offset     (offset)
    );

    ptw_entry_check #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_check (
        .entry      (entry_q),
        .access     (access_q),
        .offset     (offset),
        .fault_code (chk_fault),
        .phys       (chk_phys),
        .frame      (chk_frame),
        .perm       (chk_perm)
    );

    // Request capture: only when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            base_q   <= '0;
            access_q <= '0;
        end else if (accept) begin
            vaddr_q  <= req_vaddr;
            base_q   <= req_base;
            access_q <= req_access;
        end
    end

    // Entry capture on response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       entry_q <= '0;
        else if (capture) entry_q <= mem_rsp_data;
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault    <= FLT_NONE;
            paddr    <= '0;
            pte_pfn  <= '0;
            pte_perm <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                fault    <= chk_fault;
                paddr    <= chk_phys;
                pte_pfn  <= chk_frame;
                pte_perm <= chk_perm;
            end
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != FLT_NONE) |-> (paddr == '0)); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == FLT_NONE) |-> (paddr[PAGE_SHIFT-1:0] == vaddr_q[PAGE_SHIFT-1:0])); // R6
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [31:0] req_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        busy, done;
    logic [1:0]  fault;
    logic [31:0] paddr;
    logic [19:0] pte_pfn;
    logic [2:0]  pte_perm;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_access(req_access), .req_base(req_base), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
        .done(done), .fault(fault), .paddr(paddr), .pte_pfn(pte_pfn), .pte_perm(pte_perm)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One complete walk with a memory model; optional stray request while busy
    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                        input logic [31:0] entry, input int ready_dly, input int rsp_dly,
                        input logic [1:0] exp_fault, input bit stray);
        logic [31:0] exp_addr;
        logic [31:0] exp_pa;
        exp_addr = base + {10'd0, va[31:12], 2'b00};
        exp_pa   = (exp_fault == 2'd0) ? {entry[31:12], va[11:0]} : 32'd0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_access = acc; req_base = base;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'hDEAD_BEEF; req_base = 32'h0BAD_0000;
        check(mem_req_valid === 1'b1, "R2 request raised", {31'd0, mem_req_valid}, 32'd1);
        check(mem_req_addr === exp_addr, "R2 entry address", mem_req_addr, exp_addr);
        check(busy === 1'b1, "R8 busy during walk", {31'd0, busy}, 32'd1);
        for (int i = 0; i < ready_dly; i++) begin
            if (stray && i == 0) begin
                req_valid = 1'b1; req_vaddr = va ^ 32'h0040_0000;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R2 request held",
                  mem_req_addr, exp_addr);
            if (stray) check(mem_req_addr === exp_addr, "R9 stray ignored (addr)", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid === 1'b0, "R2 request dropped", {31'd0, mem_req_valid}, 32'd0);
        for (int i = 0; i < rsp_dly; i++) begin
            if (stray && i == 0) begin
                req_valid = 1'b1; req_vaddr = va ^ 32'h0080_0000;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check(done === 1'b0, "R3 no early done", {31'd0, done}, 32'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = entry;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hFFFF_FFFF;
        check(done === 1'b0, "R3 done not in check cycle", {31'd0, done}, 32'd0);
        @(negedge clk);
        check(done === 1'b1, "R3 done second cycle after response", {31'd0, done}, 32'd1);
        check(busy === 1'b0, "R8 busy low with done", {31'd0, busy}, 32'd0);
        check(fault === exp_fault, "R4/R5/R6/R10 fault code", {30'd0, fault}, {30'd0, exp_fault});
        check(paddr === exp_pa, "R6 physical address", paddr, exp_pa);
        check(pte_pfn === entry[31:12], "R7 frame number", {12'd0, pte_pfn}, {12'd0, entry[31:12]});
        check(pte_perm === entry[3:1], "R7 permission bits", {29'd0, pte_perm}, {29'd0, entry[3:1]});
        @(negedge clk);
        check(done === 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
        check(mem_req_valid === 1'b0 && busy === 1'b0, "R9 no second walk",
              {30'd0, busy, mem_req_valid}, 32'd0);
    endtask

    task automatic test_reset();
        check(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0, "R1 reset controls",
              {29'd0, busy, done, mem_req_valid}, 32'd0);
        check(fault === 2'd0 && paddr === 32'd0, "R1 reset result", paddr, 32'd0);
    endtask

    task automatic test_read_ok();
        walk(32'h0001_2345, 2'd0, 32'h0000_5000, 32'hABCDE_003, 0, 0, 2'd0, 0); // R6
    endtask

    task automatic test_write_stalled();
        walk(32'h0040_1ABC, 2'd1, 32'h0002_0000, 32'h12345_005, 3, 2, 2'd0, 0); // R2 R3 R6
    endtask

    task automatic test_exec_denied();
        walk(32'h0000_3010, 2'd2, 32'h0000_5000, 32'h77777_007, 1, 1, 2'd2, 0); // R5
    endtask

    task automatic test_write_denied();
        walk(32'h0000_4FFF, 2'd1, 32'h0000_5000, 32'h55555_00B, 0, 1, 2'd2, 0); // R5
    endtask

    task automatic test_read_denied();
        walk(32'h0000_6000, 2'd0, 32'h0000_5000, 32'h66666_00D, 0, 0, 2'd2, 0); // R5
    endtask

    task automatic test_invalid();
        walk(32'h0000_7123, 2'd0, 32'h0000_5000, 32'h99999_00E, 0, 0, 2'd1, 0); // R4
        walk(32'h0000_8123, 2'd1, 32'h0000_5000, 32'h88888_000, 0, 0, 2'd1, 0); // R10
    endtask

    task automatic test_reserved();
        walk(32'h0000_9000, 2'd3, 32'h0000_5000, 32'h44444_00F, 0, 0, 2'd2, 0); // R5
    endtask

    task automatic test_stray_and_top();
        walk(32'hFFFF_F123, 2'd2, 32'h0010_0000, 32'hFEDCB_009, 2, 2, 2'd0, 1); // R9 R2
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_read_ok();
        test_write_stalled();
        test_exec_denied();
        test_write_denied();
        test_read_denied();
        test_invalid();
        test_reserved();
        test_stray_and_top();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule